// File: doc/BRIEF.md
# Masked Same-Page Access Detector

This block watches processor bus cycles and tells a DRAM timing generator whether the current access lands in the same DRAM page as the last access to the DRAM region. A page is defined by a programmable mask over the word address. A mask bit of 1 makes that address bit part of the page number. A mask bit of 0 leaves that bit out of the compare.

Each bus cycle begins on the first clock edge at which the address strobe is sampled low while the bus is idle. At that edge, if detection is on and the DRAM chip select is low, the masked current address is compared with the stored masked address of the previous DRAM access. The stored address is then replaced. The result is registered. It holds the active-low flag low from the cycle after that edge until the edge at which the ready input is sampled low.

Accesses to other regions do not touch the stored address. After reset, and after any configuration write, the detector forgets the stored address, so the next DRAM access is always reported as a miss.

Top module: `samepage_detect`

## Requirements
- R1: While reset is asserted and after it is released, `pageHitN` is 1, detection is off, the mask is all ones and no previous address is held.
- R2: While the enable bit (bit 0 of the control word) is 0, `pageHitN` is 1. A control write with bit 0 clear drives `pageHitN` to 1 from the next cycle, even in the middle of a bus cycle.
- R3: A bus cycle is a hit when all of the following hold: detection is enabled, `dramSelN` is 0 at the start edge, a previous address is held, and the masked current address equals the stored masked previous address. On a hit, `pageHitN` is 0 from the cycle after the start edge.
- R4: A hit stays asserted while `readyN` is 1. It is released to 1 in the cycle after the edge at which `readyN` is sampled 0.
- R5: Mask bit i set to 1 compares address bit i. Mask bit i set to 0 ignores it, so two addresses that differ only in unmasked bits hit.
- R6: A bus cycle with `dramSelN` = 1 never asserts `pageHitN` and leaves the stored previous address unchanged.
- R7: The first enabled DRAM access after reset, or after any configuration write, is a miss. That access still records its address.
- R8: Only the first strobe-low edge of an idle bus starts a cycle. Strobe activity and address changes while the bus is busy cause no new compare and no update. `readyN` low while idle has no effect.
- R9: A configuration write with `cfgSel` = 0 loads the mask from `cfgData`. A write with `cfgSel` = 1 loads the enable from `cfgData[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrIn | input | ADDR_W | Word address of the access (address bits 27:2) |
| strobeN | input | 1 | Address strobe, active low |
| readyN | input | 1 | Ready input, active low; ends the bus cycle |
| dramSelN | input | 1 | DRAM region chip select, active low |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0 selects the mask word, 1 selects the control word |
| cfgData | input | ADDR_W | Configuration write data |
| pageHitN | output | 1 | Same-page flag, active low |

## Verification
The bench goes after the places where the hold and the stored address are easy to get wrong. One case re-pulses the strobe with a new address inside a busy cycle; a design that recompares there would drop or flip the flag mid-cycle, or would overwrite the stored page. Accesses to another region sit between two DRAM accesses to the same page; a design that records every access would report a miss on the second DRAM access. Mask tests use addresses that differ only in ignored bits, and others that differ in one compared bit; an inverted mask sense flips both outcomes. Enable is cleared in the middle of a held hit, and accesses follow reset and every configuration write; a design that keeps a stale valid flag reports a false first hit.

// File: rtl/samepage_pkg.sv
package samepage_pkg;

  typedef enum logic {
    BUS_IDLE = 1'b0,
    BUS_BUSY = 1'b1
  } busState_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic startBus;   // first strobe-low edge of an idle bus
    logic startDram;  // startBus to the DRAM region with detection enabled
    logic endBus;     // ready sampled low during a busy cycle
    logic wrMask;     // configuration write to the mask word
    logic wrCtrl;     // configuration write to the control word
  } ctrlStrobes_t;

endpackage

// File: rtl/samepage_ctrl.sv
module samepage_ctrl
  import samepage_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         strobeN,
  input  logic         readyN,
  input  logic         dramSelN,
  input  logic         enQ,
  input  logic         cfgWrEn,
  input  logic         cfgSel,
  output ctrlStrobes_t strobes,
  output logic         busy
);

  busState_e stateQ, stateD;

  always_comb begin
    strobes = '0;
    stateD  = stateQ;
    strobes.wrMask = cfgWrEn & ~cfgSel;
    strobes.wrCtrl = cfgWrEn &  cfgSel;
    unique case (stateQ)
      BUS_IDLE: begin
        if (!strobeN) begin
          strobes.startBus  = 1'b1;
          strobes.startDram = ~dramSelN & enQ;
          stateD            = BUS_BUSY;
        end
      end
      BUS_BUSY: begin
        if (!readyN) begin
          strobes.endBus = 1'b1;
          stateD         = BUS_IDLE;
        end
      end
      default: stateD = BUS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= BUS_IDLE;
    else       stateQ <= stateD;
  end

  assign busy = (stateQ == BUS_BUSY);

  // a start always moves the bus to busy, so two starts never follow each other
  assert_single_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startBus |=> !strobes.startBus);

  // a busy cycle only ends through ready
  assert_busy_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && readyN) |=> busy);

endmodule

// File: rtl/samepage_dp.sv
module samepage_dp
  import samepage_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [ADDR_W-1:0] cfgData,
  input  ctrlStrobes_t      strobes,
  output logic              enQ,
  output logic              validQ,
  output logic              hitQ,
  output logic              pageHitN
);

  localparam logic [ADDR_W-1:0] MASK_RESET = '1;
  localparam int                EN_BIT     = 0;

  logic [ADDR_W-1:0] maskQ;
  logic [ADDR_W-1:0] prevQ;
  logic [ADDR_W-1:0] bitMatch;
  logic              pageMatch;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= MASK_RESET;
      enQ   <= 1'b0;
    end else begin
      if (strobes.wrMask) maskQ <= cfgData;
      if (strobes.wrCtrl) enQ   <= cfgData[EN_BIT];
    end
  end

  // per-bit compare: unmasked bits always match
  for (genvar i = 0; i < ADDR_W; i++) begin : g_bitCmp
    assign bitMatch[i] = ~maskQ[i] | ~(addrIn[i] ^ prevQ[i]);
  end
  assign pageMatch = &bitMatch;

  // previous page and its valid flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ  <= '0;
      validQ <= 1'b0;
    end else begin
      if (strobes.startDram) prevQ <= addrIn & maskQ;
      if (strobes.wrMask || strobes.wrCtrl) validQ <= 1'b0;
      else if (strobes.startDram)           validQ <= 1'b1;
    end
  end

  // hit flag, held for the whole bus cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitQ <= 1'b0;
    end else if (strobes.startBus) begin
      hitQ <= strobes.startDram & validQ & pageMatch;
    end else if (strobes.endBus) begin
      hitQ <= 1'b0;
    end
  end

  assign pageHitN = ~(hitQ & enQ);

  // a hit can only rise on an enabled DRAM start with a held page
  assert_hit_needs_page_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hitQ) |-> $past(strobes.startDram && validQ));

  // any configuration write forgets the page
  assert_cfg_forgets_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrMask || strobes.wrCtrl) |=> !validQ);

  // the hit only falls at the end of a bus cycle
  assert_release_on_end_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hitQ) |-> $past(strobes.endBus));

endmodule

// File: rtl/samepage_detect.sv
module samepage_detect
  import samepage_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              strobeN,
  input  logic              readyN,
  input  logic              dramSelN,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  output logic              pageHitN
);

  ctrlStrobes_t strobes;
  logic         busy;
  logic         enQ;
  logic         validQ;
  logic         hitQ;

  samepage_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .strobeN  (strobeN),
    .readyN   (readyN),
    .dramSelN (dramSelN),
    .enQ      (enQ),
    .cfgWrEn  (cfgWrEn),
    .cfgSel   (cfgSel),
    .strobes  (strobes),
    .busy     (busy)
  );

  samepage_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .addrIn   (addrIn),
    .cfgData  (cfgData),
    .strobes  (strobes),
    .enQ      (enQ),
    .validQ   (validQ),
    .hitQ     (hitQ),
    .pageHitN (pageHitN)
  );

  assert_reset_high_R1: assert property (@(posedge clk)
    !rstN |-> pageHitN);

  assert_disable_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgSel && !cfgData[0]) |=> pageHitN);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!pageHitN && readyN && !cfgWrEn) |=> !pageHitN);

  assert_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!pageHitN && !readyN) |=> pageHitN);

  assert_other_region_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !strobeN && dramSelN) |=> pageHitN);

  assert_hit_in_cycle_R4: assert property (@(posedge clk) disable iff (!rstN)
    !pageHitN |-> busy);

endmodule

// File: tb/sim_samepage_detect.sv
module sim_samepage_detect;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 26;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic          strobeN = 1'b1;
  logic          readyN = 1'b1;
  logic          dramSelN = 1'b1;
  logic          cfgWrEn = 1'b0;
  logic          cfgSel = 1'b0;
  logic [AW-1:0] cfgData = '0;
  logic          pageHitN;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // behavioural reference state
  logic [AW-1:0] mMask;
  logic [AW-1:0] mPrev;
  bit mEn, mValid, mHit, mBusy;

  samepage_detect #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .strobeN(strobeN),
    .readyN(readyN), .dramSelN(dramSelN), .cfgWrEn(cfgWrEn),
    .cfgSel(cfgSel), .cfgData(cfgData), .pageHitN(pageHitN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit actual, bit expected, string req);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s pageHitN actual=%0b expected=%0b at %0t", req, actual, expected, $time);
    end
  endtask

  function automatic void modelEdge();
    bit nEn, nValid, nHit, nBusy;
    logic [AW-1:0] nMask, nPrev;
    if (!rstN) begin
      mMask = '1; mPrev = '0; mEn = 0; mValid = 0; mHit = 0; mBusy = 0;
      return;
    end
    nEn = mEn; nValid = mValid; nHit = mHit; nBusy = mBusy; nMask = mMask; nPrev = mPrev;
    if (!mBusy) begin
      if (!strobeN) begin
        nBusy = 1;
        if (mEn && !dramSelN) begin
          nHit = mValid && ((addrIn & mMask) == mPrev);
          nPrev = addrIn & mMask;
          nValid = 1;
        end else begin
          nHit = 0;
        end
      end
    end else if (!readyN) begin
      nBusy = 0;
      nHit = 0;
    end
    if (cfgWrEn) begin
      if (cfgSel) nEn = cfgData[0];
      else        nMask = cfgData;
      nValid = 0;
    end
    mEn = nEn; mValid = nValid; mHit = nHit; mBusy = nBusy; mMask = nMask; mPrev = nPrev;
  endfunction

  // one clock: model follows the edge, output compared at the falling edge
  task automatic tick(string req);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    check(pageHitN, !(mHit && mEn), req);
  endtask

  task automatic cfgWrite(bit sel, logic [AW-1:0] data, string req);
    cfgWrEn = 1; cfgSel = sel; cfgData = data;
    tick(req);
    cfgWrEn = 0;
  endtask

  // expHit: hand-computed expectation checked right after the start edge
  task automatic busCycle(logic [AW-1:0] addr, bit dram, int waitN,
                          bit expHit, string req);
    addrIn = addr; dramSelN = !dram; strobeN = 0; readyN = 1;
    tick(req);
    check(pageHitN, !expHit, req);
    strobeN = 1;
    for (int i = 0; i < waitN; i++) begin
      tick(req);
      check(pageHitN, !expHit, {req, " hold R4"});
    end
    readyN = 0;
    tick(req);
    readyN = 1; dramSelN = 1;
    tick(req);
    check(pageHitN, 1'b1, {req, " release R4"});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    modelEdge();
    @(negedge clk);
    check(pageHitN, 1'b1, "R1 in reset");
    tick("R1");
    rstN = 1;
    tick("R1");
    check(pageHitN, 1'b1, "R1 after reset");

    // R2: disabled, identical accesses never flag
    busCycle(26'h0001234, 1, 1, 0, "R2 disabled first");
    busCycle(26'h0001234, 1, 1, 0, "R2 disabled repeat");

    // R9 enable, full mask from reset
    cfgWrite(1, 26'h1, "R9 enable");
    busCycle(26'h0001234, 1, 2, 0, "R7 first after enable");
    busCycle(26'h0001234, 1, 3, 1, "R3 same page hit");
    busCycle(26'h0001235, 1, 0, 0, "R3 one bit differs");
    busCycle(26'h0001235, 1, 0, 1, "R3 hit no wait");

    // R5: mask out low 8 bits
    cfgWrite(0, 26'h3FFFF00, "R9 mask write");
    busCycle(26'h0000100, 1, 1, 0, "R7 first after mask write");
    busCycle(26'h00001FF, 1, 1, 1, "R5 ignored bits differ");
    busCycle(26'h0000200, 1, 1, 0, "R5 compared bit differs");
    busCycle(26'h00002AB, 1, 1, 1, "R5 new page hit");

    // R6: other region neither flags nor disturbs
    busCycle(26'h0000900, 0, 1, 0, "R6 other region");
    busCycle(26'h00002CD, 0, 1, 0, "R6 other region same page");
    busCycle(26'h0000211, 1, 1, 1, "R6 page kept");

    // R8: re-strobe with a new address while busy
    addrIn = 26'h0000222; dramSelN = 0; strobeN = 0; readyN = 1;
    tick("R8 start");
    check(pageHitN, 1'b0, "R8 start hit");
    addrIn = 26'h0005500; strobeN = 1; tick("R8 busy");
    strobeN = 0; tick("R8 re-strobe");
    check(pageHitN, 1'b0, "R8 re-strobe ignored");
    tick("R8 strobe held");
    readyN = 0; tick("R8 end");
    readyN = 1; strobeN = 1; dramSelN = 1; tick("R8 idle");
    check(pageHitN, 1'b1, "R8 released");
    readyN = 0; tick("R8 ready idle"); tick("R8 ready idle");
    readyN = 1;
    busCycle(26'h0000233, 1, 1, 1, "R8 page not replaced");

    // R2: disable in the middle of a held hit
    addrIn = 26'h0000244; dramSelN = 0; strobeN = 0;
    tick("R2 start");
    check(pageHitN, 1'b0, "R2 hit before disable");
    strobeN = 1;
    cfgWrite(1, 26'h0, "R2 disable mid cycle");
    check(pageHitN, 1'b1, "R2 high after disable");
    readyN = 0; tick("R2 end"); readyN = 1; dramSelN = 1; tick("R2 idle");
    cfgWrite(1, 26'h1, "R9 re-enable");
    busCycle(26'h0000244, 1, 1, 0, "R7 first after re-enable");
    busCycle(26'h0000255, 1, 1, 1, "R3 hit after re-enable");

    // R1: reset mid run forgets everything
    rstN = 0; tick("R1 reset again");
    check(pageHitN, 1'b1, "R1 reset output");
    rstN = 1; tick("R1");
    cfgWrite(1, 26'h1, "R9 enable after reset");
    busCycle(26'h0000255, 1, 1, 0, "R7 first after reset");
    busCycle(26'h0000255, 1, 1, 1, "R1 full mask after reset");
    busCycle(26'h0000256, 1, 1, 0, "R1 full mask compares low bits");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule